// File: doc/BRIEF.md
# Ethernet Half-Duplex Transmit Sequencer

This block decides when a half-duplex Ethernet transmitter may put a frame on the wire, and it then sequences the bytes of that frame. Once the transmit FIFO has filled to a programmable watermark, the block takes a frame. It waits for carrier sense to go quiet and holds off for the inter-frame gap. It then drives transmit enable together with a byte stream. The stream carries the preamble, the start-of-frame delimiter, the payload read from the FIFO and an optional CRC-32 frame check sequence.

The block watches the collision input while a frame is on the wire. If a collision arrives early in the frame, the block sends a jam pattern and backs off for a random number of slot times. It then retries from the first payload byte, because the FIFO still holds the opening bytes of the frame. A collision that arrives after those retained bytes have gone out, or one collision too many, ends the frame with an abort pulse. All timing counts a bit-time tick input rather than the clock, so the same logic serves any line rate.

The FIFO is read through an address port. The block presents the payload offset it needs and takes the byte back in the same cycle. Serialisation toward the PHY, memory fetch and the receive side sit outside this block.

Top module: `eth_hd_tx_seq`

## Requirements
- R1: A frame is taken from idle only when `enable` is high, `fifo_level` is nonzero and `fifo_level` is at least `watermark`. Otherwise `tx_en` stays low. With carrier quiet and a tick every cycle, `tx_en` rises 97 clocks after the start condition is first sampled.
- R2: The first preamble byte appears after carrier sense has been low for 60 consecutive bit ticks, followed by 36 further bit ticks. This puts it 96 ticks after carrier fell. Carrier activity during the last 36 ticks is ignored.
- R3: Carrier sense high at any point in the 60-tick quiet window restarts the window from zero.
- R4: On the wire a frame appears in this order, with each byte held on `tx_data` for 8 bit ticks: seven bytes of 0x55, one byte of 0xD5, then payload bytes read at `rd_addr` = 0 up to `frame_len`-1.
- R5: When `add_fcs` is set, four FCS bytes follow the payload, least significant byte first. The FCS is the inverted reflected CRC-32 of the payload (polynomial 0xEDB88320, initial value all ones). When `add_fcs` is clear, no FCS bytes follow.
- R6: When both `bad_fcs` and `add_fcs` are set, the FCS sent is the bitwise complement of the correct FCS. When `add_fcs` is clear, `bad_fcs` has no effect.
- R7: `tx_done` is high for exactly one cycle, the first cycle in which `tx_en` is low after the last byte of a frame that completed.
- R8: A collision sampled while a frame is on the wire replaces the stream at once with 32 bit ticks of the byte 0xA5, with `tx_en` high. `tx_en` then goes low.
- R9: After the n-th collision of a frame, the gap from `tx_en` falling to the retry's `tx_en` rising is k·`SLOT_TICKS` + 96 bit ticks plus one clock. Here k lies between 0 and 2^min(n,`BACKOFF_CAP`)−1.
- R10: The collision numbered `RETRY_LIMIT` ends the frame after its jam with a one-cycle `tx_abort` and no further attempt.
- R11: A collision after `REPLAY_BYTES` bytes following the delimiter (payload plus FCS) have gone out is late. It is jammed, then aborted without retry. A collision before that point is retried.
- R12: Deferral, gap and backoff counting advance only on cycles with `bit_tick` high.
- R13: A retry resends the whole frame, from the preamble and payload offset 0 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global permission to take new frames |
| bit_tick | input | 1 | One pulse per bit time |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| fifo_level | input | LVL_W | Bytes currently held in the transmit FIFO |
| watermark | input | LVL_W | Fill level that releases a frame |
| frame_len | input | LEN_W | Payload length in bytes (at least 1) |
| add_fcs | input | 1 | Append an FCS to this frame |
| bad_fcs | input | 1 | Corrupt the appended FCS |
| rd_data | input | 8 | FIFO byte at `rd_addr` |
| rd_addr | output | LEN_W | Payload offset being sent |
| tx_en | output | 1 | Transmit enable toward the PHY |
| tx_data | output | 8 | Byte on the wire (0 when idle) |
| tx_done | output | 1 | Frame sent pulse |
| tx_abort | output | 1 | Frame dropped (late or excessive collisions) pulse |

## Verification
A wrong count in the deferral or backoff counter shows up as a `tx_en` edge that comes ticks too early or too late. The bench therefore measures every start to the exact clock, against 96 ticks or against a multiple of the slot time. A wrong byte index or state shows up within eight ticks as a byte that differs from the expected preamble, payload, FCS or jam stream. A stale attempt count or late flag shows up only at the end of a jam, as a retry that should have been an abort or the reverse. For that reason the bench drives collisions on both sides of the replay boundary and through the whole retry budget.

// File: rtl/eth_hd_tx_seq.sv
module eth_hd_tx_seq #(
  parameter int LVL_W = 8,
  parameter int LEN_W = 11,
  parameter int SLOT_TICKS = 512,
  parameter int RETRY_LIMIT = 16,
  parameter int BACKOFF_CAP = 10,
  parameter int REPLAY_BYTES = 64,
  parameter logic [7:0] JAM_BYTE = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bit_tick,
  input  logic             crs,
  input  logic             col,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] watermark,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             add_fcs,
  input  logic             bad_fcs,
  input  logic [7:0]       rd_data,
  output logic [LEN_W-1:0] rd_addr,
  output logic             tx_en,
  output logic [7:0]       tx_data,
  output logic             tx_done,
  output logic             tx_abort
);
  localparam int QUIET = 60;
  localparam int TAIL = 36;
  localparam int CNT_MAX = (SLOT_TICKS > QUIET) ? SLOT_TICKS : QUIET;
  localparam int CNT_W = $clog2(CNT_MAX);
  localparam int ATT_W = $clog2(RETRY_LIMIT + 1);
  localparam int SLOT_W = BACKOFF_CAP;

  typedef enum logic [2:0] {S_IDLE, S_DEFER, S_IFG, S_PRE, S_DATA, S_FCS, S_JAM, S_BACK} st_t;

  st_t              st;
  logic [2:0]       bitc;
  logic [LEN_W-1:0] idx, len_q;
  logic [CNT_W-1:0] cnt;
  logic [SLOT_W-1:0] slots, bo_mask;
  logic [ATT_W-1:0] att;
  logic [31:0]      crc, fcs_word;
  logic [15:0]      lfsr;
  logic             fcs_q, bad_q, late_q, late;
  logic [LEN_W:0]   pos;
  logic             byte_end, sending;
  logic [7:0]       cur;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r >> 1) ^ ((r[0] ^ d[i]) ? 32'hEDB8_8320 : 32'h0);
    return r;
  endfunction

  assign byte_end = bit_tick && (bitc == 3'd7);
  assign sending  = (st == S_PRE) || (st == S_DATA) || (st == S_FCS);
  assign tx_en    = sending || (st == S_JAM);
  assign fcs_word = bad_q ? crc : ~crc;
  assign rd_addr  = (st == S_DATA) ? idx : '0;
  assign pos      = {1'b0, idx} + ((st == S_FCS) ? {1'b0, len_q} : '0);
  assign late     = ((st == S_DATA) || (st == S_FCS)) && (pos >= (LEN_W+1)'(REPLAY_BYTES));

  always_comb begin
    case (st)
      S_PRE:   cur = (idx == LEN_W'(7)) ? 8'hD5 : 8'h55;
      S_DATA:  cur = rd_data;
      S_FCS:   cur = fcs_word[{idx[1:0], 3'b000} +: 8];
      S_JAM:   cur = JAM_BYTE;
      default: cur = 8'h00;
    endcase
  end
  assign tx_data = cur;

  always_comb
    for (int i = 0; i < SLOT_W; i++) bo_mask[i] = (int'(att) + 1 > i);

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {1'b0, lfsr[15:1]} ^ ({16{lfsr[0]}} & 16'hB400);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; bitc <= '0; idx <= '0; cnt <= '0; slots <= '0; att <= '0;
      crc <= '1; len_q <= '0; fcs_q <= 1'b0; bad_q <= 1'b0; late_q <= 1'b0;
      tx_done <= 1'b0; tx_abort <= 1'b0;
    end else begin
      tx_done  <= 1'b0;
      tx_abort <= 1'b0;
      case (st)
        S_IDLE:
          if (enable && fifo_level != '0 && fifo_level >= watermark) begin
            len_q <= frame_len; fcs_q <= add_fcs; bad_q <= bad_fcs;
            att <= '0; cnt <= '0; st <= S_DEFER;
          end
        S_DEFER:
          if (crs) cnt <= '0;
          else if (bit_tick) begin
            if (cnt == CNT_W'(QUIET - 1)) begin cnt <= '0; st <= S_IFG; end
            else cnt <= cnt + 1'b1;
          end
        S_IFG:
          if (bit_tick) begin
            if (cnt == CNT_W'(TAIL - 1)) begin
              cnt <= '0; bitc <= '0; idx <= '0; crc <= '1; st <= S_PRE;
            end else cnt <= cnt + 1'b1;
          end
        S_PRE, S_DATA, S_FCS:
          if (col) begin
            late_q <= late; bitc <= '0; idx <= '0; st <= S_JAM;
          end else if (bit_tick) begin
            bitc <= bitc + 1'b1;
            if (byte_end) begin
              case (st)
                S_PRE:
                  if (idx == LEN_W'(7)) begin idx <= '0; st <= S_DATA; end
                  else idx <= idx + 1'b1;
                S_DATA: begin
                  crc <= crc_step(crc, rd_data);
                  if (idx == len_q - 1'b1) begin
                    idx <= '0;
                    if (fcs_q) st <= S_FCS;
                    else begin st <= S_IDLE; tx_done <= 1'b1; end
                  end else idx <= idx + 1'b1;
                end
                default:
                  if (idx == LEN_W'(3)) begin st <= S_IDLE; tx_done <= 1'b1; end
                  else idx <= idx + 1'b1;
              endcase
            end
          end
        S_JAM:
          if (bit_tick) begin
            bitc <= bitc + 1'b1;
            if (byte_end) begin
              if (idx == LEN_W'(3)) begin
                idx <= '0;
                if (late_q || int'(att) + 1 >= RETRY_LIMIT) begin
                  tx_abort <= 1'b1; st <= S_IDLE;
                end else begin
                  att <= att + 1'b1; slots <= lfsr[SLOT_W-1:0] & bo_mask;
                  cnt <= '0; st <= S_BACK;
                end
              end else idx <= idx + 1'b1;
            end
          end
        S_BACK:
          if (slots == '0) begin cnt <= '0; st <= S_DEFER; end
          else if (bit_tick) begin
            if (cnt == CNT_W'(SLOT_TICKS - 1)) begin cnt <= '0; slots <= slots - 1'b1; end
            else cnt <= cnt + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) tx_done |-> (!tx_en && $past(tx_en))); // R7
  AST_ABORT_AFTER_JAM: assert property (@(posedge clk) disable iff (!rst_n) tx_abort |-> ($past(st) == S_JAM)); // R10
  AST_PRE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n) (st == S_PRE && $past(st) != S_PRE) |-> ($past(st) == S_IFG)); // R2
  AST_QUIET_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (st == S_DEFER && crs) |=> (cnt == '0)); // R3
  AST_SFD_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n) (st == S_DATA && $past(st) == S_PRE) |-> ($past(tx_data) == 8'hD5)); // R4
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IFG && !bit_tick) |=> (st == S_IFG && $stable(cnt))); // R12
  AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) int'(att) < RETRY_LIMIT); // R10
endmodule

// File: tb/tb_eth_hd_tx_seq.sv
module tb_eth_hd_tx_seq;
  localparam int LVL_W = 6, LEN_W = 8, SLOT = 16, LIM = 4, CAP = 2, REP = 8;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, bit_tick = 1'b1, crs = 1'b0, col = 1'b0;
  logic [LVL_W-1:0] fifo_level = '0, watermark = 6'd10;
  logic [LEN_W-1:0] frame_len = 8'd4;
  logic add_fcs = 1'b0, bad_fcs = 1'b0;
  logic [7:0] rd_data;
  logic [LEN_W-1:0] rd_addr;
  logic tx_en, tx_done, tx_abort;
  logic [7:0] tx_data;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a * 8'd29 + 8'h3C;
  endfunction
  assign rd_data = pat(rd_addr);

  eth_hd_tx_seq #(.LVL_W(LVL_W), .LEN_W(LEN_W), .SLOT_TICKS(SLOT), .RETRY_LIMIT(LIM),
                  .BACKOFF_CAP(CAP), .REPLAY_BYTES(REP)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bit_tick(bit_tick), .crs(crs), .col(col),
    .fifo_level(fifo_level), .watermark(watermark), .frame_len(frame_len),
    .add_fcs(add_fcs), .bad_fcs(bad_fcs), .rd_data(rd_data), .rd_addr(rd_addr),
    .tx_en(tx_en), .tx_data(tx_data), .tx_done(tx_done), .tx_abort(tx_abort));

  int n_chk = 0, n_fail = 0;
  logic [7:0] got[$], exq[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input int len);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int a = 0; a < len; a++) begin
      logic [7:0] d = pat(8'(a));
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ d[b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return c;
  endfunction

  task automatic build_exp(input int len, input bit f, input bit b);
    logic [31:0] w;
    exq.delete();
    for (int i = 0; i < 7; i++) exq.push_back(8'h55);
    exq.push_back(8'hD5);
    for (int i = 0; i < len; i++) exq.push_back(pat(8'(i)));
    if (f) begin
      w = ~crc_of(len);
      if (b) w = ~w;
      for (int i = 0; i < 4; i++) exq.push_back(w[8*i +: 8]);
    end
  endtask

  task automatic wait_tx(output int n);
    n = 0;
    while (!tx_en && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic capture_cmp(input string req);
    int bad_i;
    got.delete();
    while (tx_en) begin got.push_back(tx_data); @(negedge clk); end
    chk(got.size() == exq.size() * 8, req, got.size(), exq.size() * 8);
    bad_i = -1;
    for (int i = 0; i < got.size() && i < exq.size() * 8; i++)
      if (bad_i < 0 && got[i] != exq[i/8]) bad_i = i;
    if (bad_i >= 0) chk(1'b0, req, got[bad_i], exq[bad_i/8]);
    else chk(1'b1, req, 0, 0);
    chk(tx_done == 1'b1, "R7 done at fall", tx_done, 1);
    @(negedge clk);
    chk(tx_done == 1'b0, "R7 done one cycle", tx_done, 0);
  endtask

  task automatic set_frame(input int len, input bit f, input bit b);
    frame_len = 8'(len); add_fcs = f; bad_fcs = b;
  endtask

  task automatic jam_check();
    bit ok = 1'b1;
    col = 1'b1;
    @(negedge clk);
    col = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (!(tx_en && tx_data == 8'hA5)) ok = 1'b0;
      if (i < 31) @(negedge clk);
    end
    @(negedge clk);
    chk(ok, "R8 jam stream", ok, 1);
    chk(!tx_en, "R8 enable low after jam", tx_en, 0);
  endtask

  task automatic gap_check(input int attempt);
    int n, k, mx;
    wait_tx(n);
    k = (n - 97) / SLOT;
    mx = (1 << ((attempt < CAP) ? attempt : CAP)) - 1;
    chk(n >= 97 && (n - 97) % SLOT == 0 && k <= mx, "R9 backoff gap", n, 97 + SLOT * mx);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_en && tx_data == 8'h00 && !tx_done && !tx_abort, "R1 reset state", tx_en, 0);

    // R1 start gate
    enable = 1'b1; fifo_level = 6'd9;
    repeat (200) @(negedge clk);
    chk(!tx_en, "R1 below watermark", tx_en, 0);
    enable = 1'b0; fifo_level = 6'd20;
    repeat (200) @(negedge clk);
    chk(!tx_en, "R1 disabled", tx_en, 0);
    enable = 1'b1; watermark = 6'd0; fifo_level = 6'd0;
    repeat (200) @(negedge clk);
    chk(!tx_en, "R1 empty fifo", tx_en, 0);
    watermark = 6'd10;

    // R4 R5 R6 R7 sweep
    foreach (n_lens[li]) ;
    for (int li = 0; li < 4; li++) begin
      for (int m = 0; m < 4; m++) begin
        int len = (li == 0) ? 1 : (li == 1) ? 3 : (li == 2) ? 8 : 13;
        set_frame(len, m[0], m[1]);
        fifo_level = 6'd10;
        wait_tx(n);
        fifo_level = 6'd0;
        chk(n == 97, "R1 start latency", n, 97);
        build_exp(len, m[0], m[1]);
        capture_cmp(m[0] ? (m[1] ? "R6 bad fcs frame" : "R5 fcs frame") : (m[1] ? "R6 bad ignored" : "R4 plain frame"));
      end
    end

    // R2 deferral while carrier busy
    set_frame(3, 1'b1, 1'b0); build_exp(3, 1'b1, 1'b0);
    crs = 1'b1; fifo_level = 6'd10;
    repeat (100) @(negedge clk);
    fifo_level = 6'd0;
    chk(!tx_en, "R2 defer on carrier", tx_en, 0);
    crs = 1'b0;
    wait_tx(n);
    chk(n == 96, "R2 gap after carrier", n, 96);
    capture_cmp("R4 frame after defer");

    // R3 restart in quiet window
    crs = 1'b1; fifo_level = 6'd10;
    repeat (10) @(negedge clk);
    fifo_level = 6'd0; crs = 1'b0;
    repeat (40) @(negedge clk);
    crs = 1'b1;
    @(negedge clk);
    crs = 1'b0;
    wait_tx(n);
    chk(n == 96, "R3 quiet window restart", n, 96);
    capture_cmp("R4 frame after restart");

    // R2 carrier ignored in the tail
    crs = 1'b1; fifo_level = 6'd10;
    repeat (10) @(negedge clk);
    fifo_level = 6'd0; crs = 1'b0;
    repeat (70) @(negedge clk);
    crs = 1'b1;
    repeat (5) @(negedge clk);
    crs = 1'b0;
    wait_tx(n);
    chk(n + 75 == 96, "R2 tail ignores carrier", n + 75, 96);
    capture_cmp("R4 frame after tail carrier");

    // R12 no tick, no progress
    bit_tick = 1'b0; fifo_level = 6'd10;
    repeat (300) @(negedge clk);
    fifo_level = 6'd0;
    chk(!tx_en, "R12 stalled without tick", tx_en, 0);
    bit_tick = 1'b1;
    wait_tx(n);
    chk(n == 96, "R12 count resumes", n, 96);
    capture_cmp("R4 frame after stall");

    // R8 R9 R13 early collision, then replay
    set_frame(12, 1'b1, 1'b0); build_exp(12, 1'b1, 1'b0);
    fifo_level = 6'd10; wait_tx(n); fifo_level = 6'd0;
    repeat (80) @(negedge clk);
    jam_check();
    chk(!tx_abort, "R11 early collision retried", tx_abort, 0);
    gap_check(1);
    capture_cmp("R13 replayed frame");

    // R11 boundary: last non-late byte
    fifo_level = 6'd10; wait_tx(n); fifo_level = 6'd0;
    repeat (123) @(negedge clk);
    jam_check();
    chk(!tx_abort, "R11 byte 7 retried", tx_abort, 0);
    gap_check(1);
    capture_cmp("R13 replay after byte 7");

    // R11 late collision
    fifo_level = 6'd10; wait_tx(n); fifo_level = 6'd0;
    repeat (129) @(negedge clk);
    jam_check();
    chk(tx_abort == 1'b1, "R11 late abort", tx_abort, 1);
    wait_tx(n);
    chk(!tx_en, "R11 no retry after late", tx_en, 0);

    // R10 retry limit
    set_frame(4, 1'b0, 1'b0);
    fifo_level = 6'd10; wait_tx(n); fifo_level = 6'd0;
    for (int a = 1; a <= LIM; a++) begin
      repeat (10) @(negedge clk);
      jam_check();
      if (a < LIM) begin
        chk(!tx_abort, "R10 no abort before limit", tx_abort, 0);
        gap_check(a);
      end else begin
        chk(tx_abort == 1'b1, "R10 abort at limit", tx_abort, 1);
        @(negedge clk);
        chk(!tx_abort, "R10 abort one cycle", tx_abort, 0);
      end
    end
    wait_tx(n);
    chk(!tx_en, "R10 no attempt after limit", tx_en, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int n_lens[1];

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule